// File: doc/BRIEF.md
# Segmented Low-Jitter Fractional Divider

This block divides an oscillator clock by a whole number that may change on every reference period. In a fractional-N loop that number comes from a third-order delta-sigma modulator. The useful range is 64 to 127. The block does not count the whole value in one run. It splits each period into four consecutive sub-counts, so its internal counter finishes four times per reference period. Only the end of the last sub-count is sent on to the time-to-digital converter, as a one-clock pulse.

Three of the sub-counts have a fixed length of `SEG_NOM` oscillator cycles. All of the dithered part of the divide value goes into the third sub-count, whose end is never forwarded. The sub-count that produces the forwarded edge therefore always has the same length. As a result, the delay from the oscillator to the measured edge does not depend on the divide value the modulator chooses.

The divide word is sampled once per frame, on the clock edge where the forwarded sub-count ends and a new frame begins. A word that changes in the middle of a frame is not seen until the next frame boundary.

Top module: `seg_frac_div`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it falls, `edge_o` is 0.
- R2: The number of `clk_i` cycles between two consecutive `edge_o` pulses equals the divide word in force for that frame.
- R3: The divide word is captured only on the clock edge that raises `edge_o` (the frame boundary), and on the first clock edge after reset. The word captured there sets the length of the next frame. Changes to `div_word_i` at any other time do not alter the frame in progress.
- R4: Each `edge_o` pulse is exactly one `clk_i` cycle wide.
- R5: A divide word below `DIV_MIN` (64 by default) is treated as `DIV_MIN`. The 7-bit word cannot exceed 127, so 127 is used as given.
- R6: The first, second and fourth sub-counts each last `SEG_NOM` (16) cycles. The third sub-count lasts N − 3·`SEG_NOM` cycles, which ranges from 16 to 79. The sub-count that ends in the forwarded edge never changes length.
- R7: The sub-counts always run in the fixed order first, second, variable, forwarded, and then wrap. There is exactly one `edge_o` pulse per four sub-counts.
- R8: When reset is released with word W present, counting from the first clock edge with `rst_i` low as edge 1, the first `edge_o` pulse is raised on clock edge W+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock being divided |
| rst_i | input | 1 | Synchronous active-high reset |
| div_word_i | input | 7 | Requested total divide value for a frame (64..127) |
| edge_o | output | 1 | Registered one-cycle pulse sent to the TDC, once per frame |

## Verification
The bench drives a sequence that includes both ends of the range (64 and 127), steps between neighbouring values, and words below 64.

- A divider that added the dither in the wrong frame would show every interval shifted by one vector.
- A divider that sampled the word continuously would be caught by a word changed in the middle of a frame: that frame would stretch or shrink.
- A design with an off-by-one in the loading of the variable sub-count would show every interval off by one.
- A design with a wrong clamp would show a short interval for the below-range words.

A second reset in the middle of a run checks the time to the first pulse and that no pulse appears on the boot edge.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  // Sub-count identifiers in the order they run.
  typedef enum logic [1:0] {
    SEG_LEAD = 2'd0,
    SEG_PRE  = 2'd1,
    SEG_VAR  = 2'd2,
    SEG_FWD  = 2'd3
  } seg_e;

  localparam int NUM_SEG = 4;

  function automatic seg_e seg_after(input seg_e s);
    case (s)
      SEG_LEAD: seg_after = SEG_PRE;
      SEG_PRE:  seg_after = SEG_VAR;
      SEG_VAR:  seg_after = SEG_FWD;
      default:  seg_after = SEG_LEAD;
    endcase
  endfunction

endpackage

// File: rtl/sfd_word_prep.sv
module sfd_word_prep #(
  parameter int DIV_W   = 7,
  parameter int SEG_NOM = 16,
  parameter int DIV_MIN = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cap_i,
  input  logic [DIV_W-1:0] word_i,
  output logic [DIV_W-1:0] var_len_o
);

  localparam int FIXED_SUM = 3 * SEG_NOM;
  localparam logic [DIV_W-1:0] MIN_W   = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] FIXED_W = DIV_W'(FIXED_SUM);

  logic [DIV_W-1:0] clamped;
  logic [DIV_W-1:0] var_len_q;

  // Words below the minimum are lifted to it.
  always_comb begin
    clamped = (word_i < MIN_W) ? MIN_W : word_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      var_len_q <= MIN_W - FIXED_W;
    end else if (cap_i) begin
      var_len_q <= clamped - FIXED_W;
    end
  end

  assign var_len_o = var_len_q;

endmodule

// File: rtl/sfd_seg_ctr.sv
module sfd_seg_ctr #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          term_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign term_o = (cnt_q == '0);

endmodule

// File: rtl/sfd_seg_seq.sv
module sfd_seg_seq
  import sfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  output seg_e seg_o
);

  seg_e seg_q;

  // Reset parks in the forwarded sub-count so the first edge starts a frame.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seg_q <= SEG_FWD;
    end else if (adv_i) begin
      seg_q <= seg_after(seg_q);
    end
  end

  assign seg_o = seg_q;

endmodule

// File: rtl/seg_frac_div.sv
module seg_frac_div
  import sfd_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int SEG_NOM = 16,
  parameter int DIV_MIN = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_word_i,
  output logic             edge_o
);

  localparam int CW = DIV_W;

  seg_e          seg;
  seg_e          seg_nxt;
  logic          term;
  logic          frame_end;
  logic          boot_q;
  logic          edge_q;
  logic [CW-1:0] var_len;
  logic [CW-1:0] seg_len [NUM_SEG];
  logic [CW-1:0] load_val;

  assign frame_end = term && (seg == SEG_FWD);
  assign seg_nxt   = seg_after(seg);

  sfd_word_prep #(
    .DIV_W  (DIV_W),
    .SEG_NOM(SEG_NOM),
    .DIV_MIN(DIV_MIN)
  ) prep_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cap_i    (frame_end),
    .word_i   (div_word_i),
    .var_len_o(var_len)
  );

  // Length of each sub-count: fixed except the dithered one.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_len
    if (g == int'(SEG_VAR)) begin : g_var
      assign seg_len[g] = var_len;
    end else begin : g_fix
      assign seg_len[g] = CW'(SEG_NOM);
    end
  end

  // The next sub-count's length is loaded when the current one ends. On the
  // frame boundary the variable length is still unused, so the freshly
  // captured word is in place before the variable sub-count loads.
  assign load_val = seg_len[seg_nxt] - 1'b1;

  sfd_seg_ctr #(
    .CW(CW)
  ) ctr_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (term),
    .load_val_i(load_val),
    .term_o    (term)
  );

  sfd_seg_seq seq_i (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .adv_i(term),
    .seg_o(seg)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      boot_q <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      edge_q <= frame_end && !boot_q;
    end
  end

  assign edge_o = edge_q;

endmodule

// File: rtl/sfd_chk.sv
module sfd_chk
  import sfd_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int SEG_NOM = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             edge_o,
  input seg_e             seg,
  input logic             term,
  input logic [DIV_W-1:0] var_len
);

  localparam int GW = DIV_W + 2;

  logic [GW-1:0] fwd_run;
  logic [GW-1:0] gap;
  logic [GW-1:0] exp_gap;
  logic          seen;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fwd_run <= '0;
      gap     <= '0;
      exp_gap <= '0;
      seen    <= 1'b0;
    end else begin
      fwd_run <= (seg == SEG_FWD) ? fwd_run + 1'b1 : '0;
      if (edge_o) begin
        gap     <= GW'(1);
        exp_gap <= GW'(var_len) + GW'(3 * SEG_NOM);
        seen    <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) rst_i |=> !edge_o);

  // R4
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_o |=> !edge_o);

  // R6
  fwd_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_o |-> $past(fwd_run) == GW'(SEG_NOM - 1));

  // R7
  seg_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (seg != $past(seg)) |-> (seg == seg_after($past(seg))));

  // R3
  word_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(var_len) |-> $past(seg == SEG_FWD && term));

  // R2
  interval_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_o && seen) |-> gap == exp_gap);

endmodule

bind seg_frac_div sfd_chk #(
  .DIV_W  (DIV_W),
  .SEG_NOM(SEG_NOM)
) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .edge_o (edge_o),
  .seg    (seg),
  .term   (term),
  .var_len(var_len)
);

// File: tb/seg_frac_div_tb_top.sv
`timescale 1ns/1ps
module seg_frac_div_tb_top;

  localparam int NV = 24;
  localparam logic [6:0] VEC [NV] = '{
    7'd100, 7'd64,  7'd127, 7'd65,  7'd126, 7'd80,
    7'd0,   7'd30,  7'd63,  7'd64,  7'd96,  7'd97,
    7'd127, 7'd127, 7'd64,  7'd111, 7'd72,  7'd119,
    7'd88,  7'd66,  7'd125, 7'd90,  7'd70,  7'd101
  };

  logic       clk = 1'b0;
  logic       rst_i;
  logic [6:0] div_word_i;
  logic       edge_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  seg_frac_div dut_i (
    .clk_i     (clk),
    .rst_i     (rst_i),
    .div_word_i(div_word_i),
    .edge_o    (edge_o)
  );

  function automatic int clampw(input logic [6:0] w);
    return (w < 7'd64) ? 64 : int'(w);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Counts negedges until edge_o is seen high; optionally changes the word mid-frame.
  task automatic wait_pulse(input int chg_at, input logic [6:0] chg_val, output int n);
    bit got;
    n = 0;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      n++;
      if (n == 1) check(edge_o == 1'b0, "R4 pulse width", int'(edge_o), 0);
      if (n == chg_at) div_word_i = chg_val;
      if (edge_o) got = 1'b1;
      if (n > 400) begin
        check(1'b0, "R2 watchdog no pulse", n, 0);
        got = 1'b1;
      end
    end
  endtask

  task automatic do_reset(input logic [6:0] w);
    rst_i = 1'b1;
    div_word_i = w;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(edge_o == 1'b0, "R1 low in reset", int'(edge_o), 0);
    end
    rst_i = 1'b0;
  endtask

  initial begin
    int n;
    int prev;
    do_reset(7'd80);
    // R8 first pulse W+1 negedges after release; R1 checked at n==1
    wait_pulse(0, 7'd0, n);
    check(n == 81, "R8 first pulse", n, 81);
    prev = 80;
    // R2 R5 R6 table walk: each interval equals the word in force for that frame
    for (int i = 0; i < NV; i++) begin
      div_word_i = VEC[i];
      wait_pulse(0, 7'd0, n);
      check(n == clampw(7'(prev)), "R2 interval", n, clampw(7'(prev)));
      prev = int'(VEC[i]);
    end
    // R3 mid-frame change must not alter the running frame
    div_word_i = 7'd90;
    wait_pulse(30, 7'd70, n);
    check(n == clampw(7'(prev)), "R3 frame kept", n, clampw(7'(prev)));
    wait_pulse(0, 7'd0, n);
    check(n == 70, "R3 late word used", n, 70);
    // R5 R6 minimum: variable sub-count at its shortest
    div_word_i = 7'd5;
    wait_pulse(0, 7'd0, n);
    check(n == 70, "R5 prior frame", n, 70);
    wait_pulse(0, 7'd0, n);
    check(n == 64, "R5 clamp to 64", n, 64);
    // R7 R8 reset mid-run with maximum word
    do_reset(7'd127);
    wait_pulse(0, 7'd0, n);
    check(n == 128, "R8 first pulse max", n, 128);
    wait_pulse(0, 7'd0, n);
    check(n == 127, "R7 one pulse per frame", n, 127);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 20);
        check(1'b0, "R2 global watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule